// File: doc/BRIEF.md
# Panel Power-Mode Sequencer

This block walks a small TFT panel controller between three power states (deep standby, sleep and normal) without software stepping each write. A request names a target state. The sequencer then emits an ordered stream of 9-bit words to a serial writer. Bit 8 of each word is 1 for a data byte and 0 for a command byte. Between words it inserts millisecond pauses. A move between deep standby and normal always passes through sleep.

The resolution select (full or quarter resolution) changes the codes written on the way into normal. A resolution change made while the panel is in normal replays the path to sleep and back to normal. A guard timer keeps every sleep-in and sleep-out command at least 120 ms apart. When waking from deep standby, the block replays a short tuning table. The block drives a pixel-clock enable, shows the current state and raises an error flag when the writer reports a fault.

Top module: `panel_power_seq`

## Requirements
- R1: After reset, `mode` is 0 (deep standby), `res_qvga` is 0, `pix_clk_en`, `err_flag` and `busy` are 0, and no word is offered.
- R2: Mode codes are 0 = deep standby, 1 = sleep and 2 = normal. A move from deep standby to sleep emits the following words in this order:
  - command 00, three times;
  - command B0, data 11;
  - command BC, data 28;
  - a tuning table of commands B1, B2, B3, B4, B5, B6, B7 and B9, each followed by its data byte 56, 33, 11, 02, 2B, 40, 03 and 04 respectively.
- R3: Each of the three wake commands is followed by a pause of at least 1 ms before the next word.
- R4: A move from sleep to normal emits the following words:
  - command BC, then data 80 (full resolution) or data 81 (quarter resolution);
  - command 3B, then data 00 (full resolution) or data 22 (quarter resolution);
  - command B0, data 16;
  - command B8, data FF, data F9;
  - command 29;
  - command 11.
- R5: Commands 3B and 28 are never accepted less than 120 ms after the last accepted sleep command (10 or 11), or after reset.
- R6: A move from normal to sleep emits command 28, then command B8, data 80, data 08, then command 10.
- R7: A move from sleep to deep standby emits command B0, then data 00.
- R8: Moves between deep standby and normal run the two single-step sequences back to back through sleep, and end in the requested mode.
- R9: `pix_clk_en` rises when a request for normal is accepted. It falls on any successful move to a mode other than normal, and it is 1 whenever `mode` is 2.
- R10: A request for the current mode emits no words, leaves `busy` low and leaves the mode unchanged.
- R11: A change of resolution while in normal emits the normal-to-sleep words, then the sleep-to-normal words with the new codes. In any other mode, the change only updates `res_qvga` and emits no words.
- R12: If `wr_err` is high when a word is accepted, the sequence still runs to its end. `err_flag` is then set, `mode` keeps its old value, and a failed resolution change restores the old resolution. Any newly accepted request clears `err_flag`.
- R13: Mode code 3 is rejected: it sets `err_flag`, emits no words and leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode request strobe, taken when not busy |
| req_mode | input | 2 | Requested mode code |
| res_valid | input | 1 | Resolution change strobe, taken when not busy |
| res_qvga_in | input | 1 | New resolution, 1 = quarter |
| wr_ready | input | 1 | Writer accepts the offered word |
| wr_err | input | 1 | Writer fault for the word accepted this cycle |
| wr_valid | output | 1 | A word is offered |
| wr_word | output | 9 | Word: bit 8 data flag, bits 7:0 byte |
| busy | output | 1 | A sequence is running |
| mode | output | 2 | Current mode code |
| res_qvga | output | 1 | Current resolution |
| pix_clk_en | output | 1 | Pixel clock enable |
| err_flag | output | 1 | Last request failed |

## Verification
The bench targets the guard window right after sleep-out. It sends a sleep request the moment normal is reached. A design that ignores the 120 ms rule, or restarts its timer from the wrong event, would issue display-off too early. The bench also reaches the two-step paths and a resolution change with the writer stalling. A design that picked the wrong segment order or dropped a word there would disagree with the scoreboard queue. Error injection during a resolution change checks that the mode holds and the old resolution comes back. A design that committed on failure would show the new values.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int IDX_W     = 4;
    localparam int TABLE_LEN = 16;
    localparam int TIX_W     = $clog2(TABLE_LEN);

    localparam logic [1:0] MODE_STBY  = 2'd0;
    localparam logic [1:0] MODE_SLEEP = 2'd1;
    localparam logic [1:0] MODE_NORM  = 2'd2;

    typedef enum logic [1:0] {SG_WAKE, SG_ON, SG_OFF, SG_DOWN} seg_e;
    typedef enum logic [2:0] {OP_CMD, OP_DAT, OP_WAIT, OP_GUARD, OP_MARK, OP_TABLE, OP_END} op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] arg;
    } step_t;

    typedef struct packed {
        logic             run;
        seg_e             seg;
        seg_e             seg2;
        logic             two;
        logic [IDX_W-1:0] idx;
        logic [TIX_W-1:0] tix;
        logic [7:0]       wcnt;
        logic             wact;
        logic             eacc;
        logic [1:0]       tgt;
        logic             res;
        logic             res_old;
        logic             res_chg;
        logic [1:0]       mode;
        logic             pix;
        logic             err;
    } ctl_t;

    function automatic step_t mk(op_e o, logic [7:0] a);
        step_t s;
        s.op  = o;
        s.arg = a;
        return s;
    endfunction

    // Tuning table: even index is the register command, odd index its data.
    function automatic logic [8:0] table_word(logic [TIX_W-1:0] i);
        logic [7:0] r;
        logic [7:0] d;
        case (i[TIX_W-1:1])
            3'd0:    begin r = 8'hB1; d = 8'h56; end
            3'd1:    begin r = 8'hB2; d = 8'h33; end
            3'd2:    begin r = 8'hB3; d = 8'h11; end
            3'd3:    begin r = 8'hB4; d = 8'h02; end
            3'd4:    begin r = 8'hB5; d = 8'h2B; end
            3'd5:    begin r = 8'hB6; d = 8'h40; end
            3'd6:    begin r = 8'hB7; d = 8'h03; end
            default: begin r = 8'hB9; d = 8'h04; end
        endcase
        return i[0] ? {1'b1, d} : {1'b0, r};
    endfunction

endpackage

// File: rtl/pps_ms_tick.sv
module pps_ms_tick #(
    parameter int CYC_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(CYC_PER_MS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q + CW'(1);
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(CYC_PER_MS - 1)) begin
            cnt_d = '0;
            tick  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pps_guard.sv
module pps_guard #(
    parameter int GUARD_CYC = 15000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int GW = $clog2(GUARD_CYC + 1);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)              cnt_d = GW'(GUARD_CYC);
        else if (cnt_q != '0)     cnt_d = cnt_q - GW'(1);
    end

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= GW'(GUARD_CYC);
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pps_prog.sv
module pps_prog
    import pps_pkg::*;
#(
    parameter int WAKE_MS   = 1,
    parameter int SETTLE_MS = 5
) (
    input  seg_e             seg,
    input  logic [IDX_W-1:0] idx,
    input  logic             qvga,
    output step_t            step
);
    localparam logic [7:0] WK = 8'(WAKE_MS);
    localparam logic [7:0] ST = 8'(SETTLE_MS);

    always_comb begin
        step = mk(OP_END, 8'h00);
        unique case (seg)
            SG_WAKE: case (idx)
                4'd0, 4'd2, 4'd4: step = mk(OP_CMD, 8'h00);
                4'd1, 4'd3, 4'd5, 4'd8: step = mk(OP_WAIT, WK);
                4'd6:  step = mk(OP_CMD, 8'hB0);
                4'd7:  step = mk(OP_DAT, 8'h11);
                4'd9:  step = mk(OP_CMD, 8'hBC);
                4'd10: step = mk(OP_DAT, 8'h28);
                4'd11: step = mk(OP_TABLE, 8'h00);
                default: step = mk(OP_END, 8'h00);
            endcase
            SG_ON: case (idx)
                4'd0:  step = mk(OP_GUARD, 8'h00);
                4'd1:  step = mk(OP_CMD, 8'hBC);
                4'd2:  step = mk(OP_DAT, qvga ? 8'h81 : 8'h80);
                4'd3:  step = mk(OP_CMD, 8'h3B);
                4'd4:  step = mk(OP_DAT, qvga ? 8'h22 : 8'h00);
                4'd5:  step = mk(OP_CMD, 8'hB0);
                4'd6:  step = mk(OP_DAT, 8'h16);
                4'd7:  step = mk(OP_CMD, 8'hB8);
                4'd8:  step = mk(OP_DAT, 8'hFF);
                4'd9:  step = mk(OP_DAT, 8'hF9);
                4'd10: step = mk(OP_CMD, 8'h29);
                4'd11: step = mk(OP_CMD, 8'h11);
                4'd12: step = mk(OP_MARK, 8'h00);
                4'd13: step = mk(OP_WAIT, ST);
                default: step = mk(OP_END, 8'h00);
            endcase
            SG_OFF: case (idx)
                4'd0: step = mk(OP_GUARD, 8'h00);
                4'd1: step = mk(OP_CMD, 8'h28);
                4'd2: step = mk(OP_CMD, 8'hB8);
                4'd3: step = mk(OP_DAT, 8'h80);
                4'd4: step = mk(OP_DAT, 8'h08);
                4'd5: step = mk(OP_CMD, 8'h10);
                4'd6: step = mk(OP_MARK, 8'h00);
                4'd7: step = mk(OP_WAIT, ST);
                default: step = mk(OP_END, 8'h00);
            endcase
            default: case (idx)
                4'd0: step = mk(OP_CMD, 8'hB0);
                4'd1: step = mk(OP_DAT, 8'h00);
                default: step = mk(OP_END, 8'h00);
            endcase
        endcase
    end
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
    import pps_pkg::*;
#(
    parameter int CLK_KHZ   = 125000,
    parameter int GUARD_MS  = 120,
    parameter int WAKE_MS   = 1,
    parameter int SETTLE_MS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       res_valid,
    input  logic       res_qvga_in,
    input  logic       wr_ready,
    input  logic       wr_err,
    output logic       wr_valid,
    output logic [8:0] wr_word,
    output logic       busy,
    output logic [1:0] mode,
    output logic       res_qvga,
    output logic       pix_clk_en,
    output logic       err_flag
);
    localparam int GUARD_CYC = GUARD_MS * CLK_KHZ;

    ctl_t  d, q;
    step_t step;
    logic  tick, tick_clr, guard_rst, guard_ok;

    pps_ms_tick #(.CYC_PER_MS(CLK_KHZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(tick_clr), .tick(tick));

    pps_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .restart(guard_rst), .expired(guard_ok));

    pps_prog #(.WAKE_MS(WAKE_MS), .SETTLE_MS(SETTLE_MS)) u_prog (
        .seg(q.seg), .idx(q.idx), .qvga(q.res), .step(step));

    always_comb begin
        d         = q;
        wr_valid  = 1'b0;
        wr_word   = '0;
        tick_clr  = 1'b0;
        guard_rst = 1'b0;
        if (!q.run) begin
            if (req_valid) begin
                d.err = (req_mode == 2'd3);
                if (req_mode == MODE_NORM) d.pix = 1'b1;
                if (req_mode != 2'd3 && req_mode == q.mode) begin
                    if (req_mode != MODE_NORM) d.pix = 1'b0;
                end else if (req_mode != 2'd3) begin
                    d.run     = 1'b1;
                    d.idx     = '0;
                    d.eacc    = 1'b0;
                    d.tgt     = req_mode;
                    d.res_chg = 1'b0;
                    if (q.mode == MODE_STBY) begin
                        d.seg  = SG_WAKE;
                        d.seg2 = SG_ON;
                        d.two  = (req_mode == MODE_NORM);
                    end else if (q.mode == MODE_SLEEP) begin
                        d.seg = (req_mode == MODE_NORM) ? SG_ON : SG_DOWN;
                        d.two = 1'b0;
                    end else begin
                        d.seg  = SG_OFF;
                        d.seg2 = SG_DOWN;
                        d.two  = (req_mode == MODE_STBY);
                    end
                end
            end else if (res_valid && res_qvga_in != q.res) begin
                d.err     = 1'b0;
                d.res     = res_qvga_in;
                d.res_old = q.res;
                if (q.mode == MODE_NORM) begin
                    d.run     = 1'b1;
                    d.idx     = '0;
                    d.eacc    = 1'b0;
                    d.tgt     = MODE_NORM;
                    d.res_chg = 1'b1;
                    d.seg     = SG_OFF;
                    d.seg2    = SG_ON;
                    d.two     = 1'b1;
                end
            end
        end else begin
            unique case (step.op)
                OP_CMD, OP_DAT: begin
                    wr_valid = 1'b1;
                    wr_word  = {step.op == OP_DAT, step.arg};
                    if (wr_ready) begin
                        d.eacc = q.eacc | wr_err;
                        d.idx  = q.idx + IDX_W'(1);
                    end
                end
                OP_TABLE: begin
                    wr_valid = 1'b1;
                    wr_word  = table_word(q.tix);
                    if (wr_ready) begin
                        d.eacc = q.eacc | wr_err;
                        d.tix  = q.tix + TIX_W'(1);
                        if (q.tix == TIX_W'(TABLE_LEN - 1)) d.idx = q.idx + IDX_W'(1);
                    end
                end
                OP_WAIT: begin
                    if (!q.wact) begin
                        d.wact   = 1'b1;
                        d.wcnt   = step.arg;
                        tick_clr = 1'b1;
                    end else if (tick) begin
                        if (q.wcnt <= 8'd1) begin
                            d.wact = 1'b0;
                            d.idx  = q.idx + IDX_W'(1);
                        end else begin
                            d.wcnt = q.wcnt - 8'd1;
                        end
                    end
                end
                OP_GUARD: if (guard_ok) d.idx = q.idx + IDX_W'(1);
                OP_MARK: begin
                    guard_rst = 1'b1;
                    d.idx     = q.idx + IDX_W'(1);
                end
                default: begin
                    if (q.two) begin
                        d.seg = q.seg2;
                        d.two = 1'b0;
                        d.idx = '0;
                    end else begin
                        d.run = 1'b0;
                        if (!q.eacc) begin
                            d.mode = q.tgt;
                            if (q.tgt != MODE_NORM) d.pix = 1'b0;
                        end else begin
                            d.err = 1'b1;
                            if (q.res_chg) d.res = q.res_old;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.seg  <= SG_WAKE;
            q.seg2 <= SG_WAKE;
            q.mode <= MODE_STBY;
        end else begin
            q <= d;
        end
    end

    assign busy       = q.run;
    assign mode       = q.mode;
    assign res_qvga   = q.res;
    assign pix_clk_en = q.pix;
    assign err_flag   = q.err;
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int GUARD_CYC = 15000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       res_valid,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic [8:0] wr_word,
    input logic       busy,
    input logic [1:0] mode,
    input logic       pix_clk_en
);
    localparam int CW = $clog2(GUARD_CYC + 2);

    logic [CW-1:0] since_q;
    logic          acc;
    assign acc = wr_valid && wr_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) since_q <= '0;
        else if (acc && (wr_word == 9'h010 || wr_word == 9'h011)) since_q <= '0;
        else if (since_q < CW'(GUARD_CYC)) since_q <= since_q + CW'(1);
    end

    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_word));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_valid);

    p_pix_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd2 |-> pix_clk_en);

    p_mode_legal_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

    p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !req_valid && !res_valid |=> $stable(mode));

    p_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (wr_word == 9'h028 || wr_word == 9'h03B) |-> since_q >= CW'(GUARD_CYC));
endmodule

bind panel_power_seq pps_checker #(.GUARD_CYC(GUARD_MS * CLK_KHZ)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .res_valid(res_valid),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_word(wr_word),
    .busy(busy), .mode(mode), .pix_clk_en(pix_clk_en));

// File: tb/sim_panel_power_seq.sv
`timescale 1ns/1ps
module sim_panel_power_seq;
    localparam int KHZ   = 20;
    localparam int GUARD = 120 * KHZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, res_valid = 1'b0, res_in = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic err_on = 1'b0, stall_on = 1'b0;
    logic wr_ready, wr_err, wr_valid, busy, res_qvga, pix_clk_en, err_flag;
    logic [8:0] wr_word;
    logic [1:0] mode;

    int total = 0, bad = 0, cyc = 0, accepts = 0;
    int last_sleep = 0, last_acc = 0;
    logic [8:0] prev_word = 9'h1FF;
    logic [8:0] exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign wr_ready = !(stall_on && (cyc % 3 == 0));
    assign wr_err   = err_on;

    panel_power_seq #(.CLK_KHZ(KHZ)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .res_valid(res_valid), .res_qvga_in(res_in), .wr_ready(wr_ready), .wr_err(wr_err),
        .wr_valid(wr_valid), .wr_word(wr_word), .busy(busy), .mode(mode),
        .res_qvga(res_qvga), .pix_clk_en(pix_clk_en), .err_flag(err_flag));

    task automatic check(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: compare each accepted word with the queue head.
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            accepts++;
            if (exp_q.size() == 0) check("R2 unexpected word", int'(wr_word), 9'h1FF);
            else check("R2/R4/R6/R7 word order", int'(wr_word), int'(exp_q.pop_front()));
            if (wr_word == 9'h000 && prev_word == 9'h000)
                check("R3 wake gap ok", int'(cyc - last_acc >= KHZ), 1);
            if (wr_word == 9'h028 || wr_word == 9'h03B)
                check("R5 guard ok", int'(cyc - last_sleep >= GUARD), 1);
            if (wr_word == 9'h010 || wr_word == 9'h011) last_sleep = cyc;
            prev_word = wr_word;
            last_acc  = cyc;
        end
    end

    task automatic pc(input logic [7:0] b); exp_q.push_back({1'b0, b}); endtask
    task automatic pd(input logic [7:0] b); exp_q.push_back({1'b1, b}); endtask

    task automatic exp_wake();
        logic [7:0] regs [8] = '{8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5, 8'hB6, 8'hB7, 8'hB9};
        logic [7:0] vals [8] = '{8'h56, 8'h33, 8'h11, 8'h02, 8'h2B, 8'h40, 8'h03, 8'h04};
        pc(8'h00); pc(8'h00); pc(8'h00);
        pc(8'hB0); pd(8'h11); pc(8'hBC); pd(8'h28);
        for (int i = 0; i < 8; i++) begin pc(regs[i]); pd(vals[i]); end
    endtask
    task automatic exp_on(input logic q);
        pc(8'hBC); pd(q ? 8'h81 : 8'h80); pc(8'h3B); pd(q ? 8'h22 : 8'h00);
        pc(8'hB0); pd(8'h16); pc(8'hB8); pd(8'hFF); pd(8'hF9); pc(8'h29); pc(8'h11);
    endtask
    task automatic exp_off(); pc(8'h28); pc(8'hB8); pd(8'h80); pd(8'h08); pc(8'h10); endtask
    task automatic exp_down(); pc(8'hB0); pd(8'h00); endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_req(input logic [1:0] m);
        @(posedge clk); #1 req_valid = 1'b1; req_mode = m;
        @(posedge clk); #1 req_valid = 1'b0;
        wait_idle();
        check("R2 all expected words seen", exp_q.size(), 0);
    endtask

    task automatic do_res(input logic r);
        @(posedge clk); #1 res_valid = 1'b1; res_in = r;
        @(posedge clk); #1 res_valid = 1'b0;
        wait_idle();
        check("R11 all expected words seen", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int a0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        last_sleep = cyc;
        @(negedge clk);
        check("R1 mode", mode, 0); check("R1 res", res_qvga, 0);
        check("R1 pix", pix_clk_en, 0); check("R1 err", err_flag, 0);
        check("R1 busy", busy, 0); check("R1 wr_valid", wr_valid, 0);

        exp_wake(); do_req(2'd1);
        check("R2 mode sleep", mode, 1); check("R9 pix off", pix_clk_en, 0);

        exp_on(1'b0); do_req(2'd2);
        check("R4 mode normal", mode, 2); check("R9 pix on", pix_clk_en, 1);

        exp_off(); do_req(2'd1);
        check("R6 mode sleep", mode, 1); check("R9 pix off after sleep", pix_clk_en, 0);

        exp_down(); do_req(2'd0);
        check("R7 mode standby", mode, 0);

        exp_wake(); exp_on(1'b0); do_req(2'd2);
        check("R8 standby to normal", mode, 2);

        a0 = accepts;
        do_req(2'd2);
        check("R10 no words", accepts - a0, 0);
        check("R10 mode kept", mode, 2);

        stall_on = 1'b1;
        exp_off(); exp_on(1'b1); do_res(1'b1);
        stall_on = 1'b0;
        check("R11 res quarter", res_qvga, 1); check("R11 mode normal", mode, 2);

        exp_off(); exp_down(); do_req(2'd0);
        check("R8 normal to standby", mode, 0); check("R9 pix off standby", pix_clk_en, 0);

        a0 = accepts;
        do_res(1'b0);
        check("R11 res full in standby", res_qvga, 0);
        check("R11 no words in standby", accepts - a0, 0);

        a0 = accepts;
        do_req(2'd3);
        check("R13 err set", err_flag, 1); check("R13 no words", accepts - a0, 0);
        check("R13 mode kept", mode, 0);

        exp_wake(); exp_on(1'b0); do_req(2'd2);
        check("R12 err cleared", err_flag, 0); check("R8 normal again", mode, 2);

        err_on = 1'b1;
        exp_off(); do_req(2'd1);
        check("R12 err on failure", err_flag, 1); check("R12 mode unchanged", mode, 2);
        check("R9 pix kept", pix_clk_en, 1);

        exp_off(); exp_on(1'b1); do_res(1'b1);
        check("R12 res restored", res_qvga, 0); check("R12 err res", err_flag, 1);
        err_on = 1'b0;

        exp_off(); do_req(2'd1);
        check("R12 recovered mode", mode, 1); check("R12 err clear", err_flag, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule